// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block freezes the value of a free-running 64-bit time counter at the moment a timing-protocol event packet passes the transmit or the receive path, and keeps that value until software collects it. The packet parsers outside the block reduce each packet to an event strobe plus a few decoded attributes: whether it came as a raw layer-2 frame of the timing ethertype, its protocol version, its message type and its UDP destination port. The block does not parse packets and does not own the time counter.

There are two independent channels. Each has an enable bit, a valid flag, and a 64-bit stamp that is read as a low word and then a high word. Once a channel has captured, it stays locked: later events are ignored, so the stamp can belong to only one packet. Reading the high word, or disabling the channel, releases the lock. The receive channel also qualifies events. A 2-bit mode chooses version-1 sync, version-1 delay request or all version-2 event messages. A 16-bit field gives the event UDP port. A filter bit lets raw layer-2 timing frames be stamped.

Registers are accessed through a simple word port. Writes take effect on the clock edge. Read data is combinational from the address, and a read strobe has its side effect on the edge.

Top module: `evt_time_capture`

## Requirements
- R1: After reset both enables and valid flags are 0, both stamps read 0, and the receive mode, port and filter fields read 0.
- R2: The transmit control word sits at address 0, with enable in bit 0 and valid in bit 1. When `tx_evt` is high on an edge while the transmit channel is enabled and not valid, valid reads 1 after that edge. The stamp then holds the `sys_time` value of that edge, with the low word at address 1 and the high word at address 2.
- R3: An event on a disabled channel captures nothing; valid stays 0.
- R4: While a channel is valid, further events leave its valid flag and its stamp unchanged.
- R5: A read of the high stamp word clears that channel's valid flag on the same edge and releases the lock. A read of the low word does not. The high words are at address 2 for transmit and address 6 for receive.
- R6: Writing a control word with bit 0 = 0 disables the channel, clears its valid flag and zeroes its stamp.
- R7: The receive match word at address 4 holds the event UDP port in bits 31:16. A UDP packet whose destination port differs from that field is not stamped.
- R8: The receive control word at address 3 has enable in bit 0, valid in bit 1 and mode in bits 5:4. Mode 0 stamps version-1 type 0 (sync). Mode 1 stamps version-1 type 1 (delay request). Mode 2 stamps version-2 event types 0 to 3. Mode 3 stamps nothing. Types 4 and above are never events. Receive low and high words are at addresses 5 and 6.
- R9: In mode 2, peer-delay messages (types 2 and 3) are stamped along with sync and delay request.
- R10: A layer-2 packet (`rx_is_l2` = 1) is stamped only when the filter bit 8 of the receive control word is set, the mode is 2, and the packet is a version-2 event; its port is not checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_time | input | 64 | Running time counter value |
| tx_evt | input | 1 | Transmit event strobe |
| rx_evt | input | 1 | Receive event strobe |
| rx_is_l2 | input | 1 | Receive packet is a layer-2 timing frame |
| rx_is_v2 | input | 1 | Receive packet is protocol version 2 |
| rx_msg_type | input | 4 | Decoded message type |
| rx_dst_port | input | 16 | UDP destination port of the receive packet |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |

## Verification
A capture becomes visible one edge after the strobe. The stamp equals the time value that was present at that edge. A release or disable also shows one edge after its read or write strobe. Read data, by contrast, follows the address in the same cycle. The bench drives every input just after a falling edge and samples read data before the next rising edge. That sample therefore shows the state left by the previous edge, before the side effect of the current read. Each receive qualification case in the vector table is followed by a high-word read, so every case starts from an unlocked channel.

// File: rtl/evt_time_capture.sv
module evt_time_capture #(
  parameter int TW = 64,
  parameter int AW = 3,
  parameter int PW = 16,
  parameter int YW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] sys_time,
  input  logic          tx_evt,
  input  logic          rx_evt,
  input  logic          rx_is_l2,
  input  logic          rx_is_v2,
  input  logic [YW-1:0] rx_msg_type,
  input  logic [PW-1:0] rx_dst_port,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [TW/2-1:0] reg_wdata,
  output logic [TW/2-1:0] reg_rdata
);
  localparam int DW = TW / 2;
  localparam logic [AW-1:0] A_TXC = 3'd0, A_TXL = 3'd1, A_TXH = 3'd2,
                            A_RXC = 3'd3, A_RXM = 3'd4, A_RXL = 3'd5, A_RXH = 3'd6;

  logic          tx_en, tx_valid, rx_en, rx_valid, rx_l2en;
  logic [1:0]    rx_mode;
  logic [PW-1:0] rx_port;
  logic [TW-1:0] tx_stamp, rx_stamp;

  wire wr_txc = reg_wr && reg_addr == A_TXC;
  wire wr_rxc = reg_wr && reg_addr == A_RXC;
  wire wr_rxm = reg_wr && reg_addr == A_RXM;
  wire rd_txh = reg_rd && reg_addr == A_TXH;
  wire rd_rxh = reg_rd && reg_addr == A_RXH;

  wire is_event = rx_msg_type < YW'(4);
  logic mode_ok;
  always_comb begin
    case (rx_mode)
      2'd0:    mode_ok = !rx_is_v2 && rx_msg_type == YW'(0);
      2'd1:    mode_ok = !rx_is_v2 && rx_msg_type == YW'(1);
      2'd2:    mode_ok = rx_is_v2 && is_event;
      default: mode_ok = 1'b0;
    endcase
  end
  wire udp_ok = !rx_is_l2 && rx_dst_port == rx_port && mode_ok;
  wire l2_ok  = rx_is_l2 && rx_l2en && rx_mode == 2'd2 && rx_is_v2 && is_event;

  wire tx_cap = tx_evt && tx_en && !tx_valid;
  wire rx_cap = rx_evt && rx_en && !rx_valid && (udp_ok || l2_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_en <= 1'b0; tx_valid <= 1'b0; tx_stamp <= '0;
    end else if (wr_txc) begin
      tx_en <= reg_wdata[0];
      if (!reg_wdata[0]) begin tx_valid <= 1'b0; tx_stamp <= '0; end
      else if (tx_cap) begin tx_valid <= 1'b1; tx_stamp <= sys_time; end
      else if (rd_txh) tx_valid <= 1'b0;
    end else if (tx_cap) begin
      tx_valid <= 1'b1; tx_stamp <= sys_time;
    end else if (rd_txh) tx_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en <= 1'b0; rx_valid <= 1'b0; rx_stamp <= '0;
      rx_mode <= 2'd0; rx_l2en <= 1'b0; rx_port <= '0;
    end else begin
      if (wr_rxm) rx_port <= reg_wdata[DW-1 -: PW];
      if (wr_rxc) begin
        rx_en <= reg_wdata[0]; rx_mode <= reg_wdata[5:4]; rx_l2en <= reg_wdata[8];
      end
      if (wr_rxc && !reg_wdata[0]) begin
        rx_valid <= 1'b0; rx_stamp <= '0;
      end else if (rx_cap) begin
        rx_valid <= 1'b1; rx_stamp <= sys_time;
      end else if (rd_rxh) rx_valid <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      A_TXC:   reg_rdata = {30'b0, tx_valid, tx_en};
      A_TXL:   reg_rdata = tx_stamp[DW-1:0];
      A_TXH:   reg_rdata = tx_stamp[TW-1:DW];
      A_RXC:   reg_rdata = {23'b0, rx_l2en, 2'b0, rx_mode, 2'b0, rx_valid, rx_en};
      A_RXM:   reg_rdata = {rx_port, {(DW-PW){1'b0}}};
      A_RXL:   reg_rdata = rx_stamp[DW-1:0];
      A_RXH:   reg_rdata = rx_stamp[TW-1:DW];
      default: reg_rdata = '0;
    endcase
  end

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[15:9], reg_wdata[7:6], reg_wdata[3:1]};

  AST_TX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_evt && tx_en && !tx_valid && !wr_txc) |=> (tx_valid && tx_stamp == $past(sys_time))); // R2
  AST_NO_EN_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en |-> !tx_valid) and (!rx_en |-> !rx_valid)); // R3
  AST_RX_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rd_rxh && !wr_rxc) |=> (rx_valid && $stable(rx_stamp))); // R4
  AST_TX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && rd_txh && !wr_txc) |=> !tx_valid); // R5
  AST_RX_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rxc && !reg_wdata[0]) |=> (!rx_valid && rx_stamp == '0)); // R6
endmodule

// File: tb/test_evt_time_capture.sv
module test_evt_time_capture;
  logic clk = 0, rst_n = 0;
  logic [63:0] sys_time = 64'h0123_4567_0000_1000;
  logic tx_evt = 0, rx_evt = 0, rx_is_l2 = 0, rx_is_v2 = 0;
  logic [3:0] rx_msg_type = 0;
  logic [15:0] rx_dst_port = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(negedge clk) sys_time <= sys_time + 64'h0000_0001_0000_0007;

  evt_time_capture i_evt_time_capture (.*);

  typedef struct packed {
    logic [1:0] mode; logic l2en; logic l2; logic v2;
    logic [3:0] ty; logic pm; logic exp; logic [7:0] req;
  } vec_t;
  // R7 port, R8 modes, R9 peer-delay, R10 layer-2 filter
  localparam vec_t VEC [16] = '{
    '{2'd0,1'b0,1'b0,1'b0,4'd0,1'b1,1'b1,8'd8},
    '{2'd0,1'b0,1'b0,1'b0,4'd1,1'b1,1'b0,8'd8},
    '{2'd0,1'b0,1'b0,1'b0,4'd0,1'b0,1'b0,8'd7},
    '{2'd1,1'b0,1'b0,1'b0,4'd1,1'b1,1'b1,8'd8},
    '{2'd1,1'b0,1'b0,1'b0,4'd0,1'b1,1'b0,8'd8},
    '{2'd2,1'b0,1'b0,1'b1,4'd0,1'b1,1'b1,8'd8},
    '{2'd2,1'b0,1'b0,1'b1,4'd2,1'b1,1'b1,8'd9},
    '{2'd2,1'b0,1'b0,1'b1,4'd3,1'b1,1'b1,8'd9},
    '{2'd2,1'b0,1'b0,1'b1,4'd8,1'b1,1'b0,8'd8},
    '{2'd2,1'b0,1'b0,1'b0,4'd0,1'b1,1'b0,8'd8},
    '{2'd0,1'b0,1'b0,1'b1,4'd2,1'b1,1'b0,8'd8},
    '{2'd2,1'b1,1'b1,1'b1,4'd0,1'b0,1'b1,8'd10},
    '{2'd2,1'b0,1'b1,1'b1,4'd0,1'b0,1'b0,8'd10},
    '{2'd0,1'b1,1'b1,1'b0,4'd0,1'b1,1'b0,8'd10},
    '{2'd3,1'b0,1'b0,1'b0,4'd0,1'b1,1'b0,8'd8},
    '{2'd2,1'b0,1'b0,1'b1,4'd2,1'b0,1'b0,8'd7}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    reg_addr = a; reg_rd = 1; #1;
    d = reg_rdata;
    @(negedge clk); #1;
    reg_rd = 0;
  endtask

  task automatic tx_pulse(output logic [63:0] t);
    @(negedge clk); #1;
    tx_evt = 1; t = sys_time;
    @(negedge clk); #1;
    tx_evt = 0;
  endtask

  task automatic rx_pulse(logic l2, logic v2, logic [3:0] ty, logic [15:0] p,
                          output logic [63:0] t);
    @(negedge clk); #1;
    rx_is_l2 = l2; rx_is_v2 = v2; rx_msg_type = ty; rx_dst_port = p;
    rx_evt = 1; t = sys_time;
    @(negedge clk); #1;
    rx_evt = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, lo, hi;
    logic [63:0] t, t2;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd(3'd0, d); check("R1 tx ctl", d, 0);
    rd(3'd1, d); check("R1 tx lo", d, 0);
    rd(3'd2, d); check("R1 tx hi", d, 0);
    rd(3'd3, d); check("R1 rx ctl", d, 0);
    rd(3'd4, d); check("R1 rx match", d, 0);
    rd(3'd6, d); check("R1 rx hi", d, 0);
    // R3 disabled channel ignores events
    tx_pulse(t);
    rd(3'd0, d); check("R3 tx disabled", d, 0);
    rx_pulse(0, 0, 0, 0, t);
    rd(3'd3, d); check("R3 rx disabled", d, 0);
    // R2 capture
    wr(3'd0, 1);
    tx_pulse(t);
    rd(3'd0, d); check("R2 tx valid", d, 3);
    // R4 lock
    tx_pulse(t2);
    rd(3'd1, lo); check("R2 tx lo", lo, t[31:0]);
    rd(3'd0, d); check("R5 low read keeps valid", d, 3);
    rd(3'd2, hi); check("R4 tx hi kept first", hi, t[63:32]);
    rd(3'd0, d); check("R5 high read releases", d, 1);
    tx_pulse(t2);
    rd(3'd1, lo); check("R5 recapture after release", lo, t2[31:0]);
    // R6 disable drops capture
    wr(3'd0, 0);
    rd(3'd0, d); check("R6 tx ctl", d, 0);
    rd(3'd1, d); check("R6 tx lo zero", d, 0);
    rd(3'd2, d); check("R6 tx hi zero", d, 0);
    // receive vectors
    wr(3'd4, {16'd319, 16'h0});
    rd(3'd4, d); check("R7 match field", d, {16'd319, 16'h0});
    foreach (VEC[i]) begin
      wr(3'd3, {23'b0, VEC[i].l2en, 2'b0, VEC[i].mode, 4'b0001});
      rx_pulse(VEC[i].l2, VEC[i].v2, VEC[i].ty, VEC[i].pm ? 16'd319 : 16'd320, t);
      rd(3'd3, d);
      check($sformatf("R%0d vec %0d valid", VEC[i].req, i), d[1], VEC[i].exp);
      rd(3'd5, lo);
      rd(3'd6, hi);
      if (VEC[i].exp) check($sformatf("R%0d vec %0d stamp", VEC[i].req, i), {hi, lo}, t);
      rd(3'd3, d); check($sformatf("R5 vec %0d released", i), d[1], 0);
    end
    // R4 rx lock and R6 rx disable
    wr(3'd3, 32'h21);
    rx_pulse(0, 1, 0, 16'd319, t);
    rx_pulse(0, 1, 3, 16'd319, t2);
    rd(3'd5, lo); check("R4 rx lo kept first", lo, t[31:0]);
    wr(3'd3, 32'h20);
    rd(3'd3, d); check("R6 rx ctl", d, 32'h20);
    rd(3'd5, d); check("R6 rx lo zero", d, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule